// File: doc/BRIEF.md
# Edge-Notifying Interrupt Cause and Mask Unit

This block holds the interrupt state of a network controller: a legacy cause register with its enable mask, and an extended per-vector cause register with its own enable mask. Hardware event inputs and software operations both act on these registers. The software operations are cause-set, mask-set, mask-clear, write-1-to-clear, cause-read and the four extended counterparts. A software operation is presented for one cycle on `sw_op` and `sw_wdata`.

Notification is edge based. In each cycle the unit applies the clear part of the operation, records the set of causes that are pending and enabled, merges in all new causes, and notifies only for bits that have just become pending and enabled. A cause that stays pending, or a re-raise of a cause that is already pending, never produces a second notification.

In per-vector mode, legacy causes reach extended vectors through a two-byte routing map. In single-vector mode, a summary bit in the extended register is used, and the notification goes out as vector 0, as an MSI pulse or as a level line. Which one is used depends on the enable inputs.

Top module: `nic_irq_notifier`

## Requirements
- R1: A notification (any `vec_notify` bit, `msi_pulse`, or a rise of `irq_level`) is produced only for cause bits that are pending and enabled after the operation, and that were not pending and enabled after the operation's clear step. Re-raising an already pending cause produces none.
- R2: In per-vector mode, a fresh legacy cause bit 30 (reset-asserted) is routed through `route_map[7:0]`. Any other fresh legacy cause is routed through `route_map[15:8]`. A byte acts only when its bit 7 is set, and it then sets extended cause bit `byte[4:0]`.
- R3: In per-vector mode, every extended bit that is freshly pending and enabled is pulsed on the same bit of `vec_notify`.
- R4: In single-vector mode, a fresh legacy cause sets extended bit 31, and also extended bit 30 when legacy bit 30 is among the fresh causes. The unit then pulses `vec_notify[0]` if `msix_on`, else `msi_pulse` if `msi_on`, else it sets `irq_level`.
- R5: After a clearing operation (op codes 3, 4, 5, 8, 9) in single-vector mode, if no legacy cause is left pending and enabled, extended bit 31 is cleared. `irq_level` also drops when neither `msi_on` nor `msix_on` is set.
- R6: Mask-set data (op 2) is ANDed with 0x77D4FBFD. Extended set, mask-set, mask-clear and cause-clear data (ops 6, 7, 8, 9) are ANDed with 0x01FFFFFF in per-vector mode and with 0xC000017F otherwise.
- R7: A mask-set (op 2 or 7) that enables an already pending cause notifies. Mask-clear (ops 3, 8) and cause-clear (ops 4, 9) never notify.
- R8: A cause read (op 5) loads `rd_data` with the pre-read legacy cause value. The read clears the whole legacy cause register when `force_clr` is set, when the mask is zero, or when `msix_on` is low.
- R9: After a cause read or a write-1-to-clear (op 4), the mask bits in `automask` are cleared when `force_clr` is set, or when the mask is nonzero and legacy cause bit 31 is set. A read evaluates bit 31 after its own clear; a write evaluates it before.
- R10: When a hardware event and a software clear hit the same bit in one cycle, the clear is applied first, so the bit ends up set.
- R11: All outputs are registered and change one cycle after the operation. `vec_notify` and `msi_pulse` last one cycle; `irq_level` holds until it is dropped.
- R12: Reset clears every register and output to zero.

Op codes: 0 idle, 1 cause-set, 2 mask-set, 3 mask-clear, 4 write-1-to-clear, 5 cause-read, 6 extended set, 7 extended mask-set, 8 extended mask-clear, 9 extended cause-clear. Codes 10 to 15 act as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_op | input | 4 | Software operation code, one cycle per operation |
| sw_wdata | input | CW | Operation data |
| hw_cause | input | CW | Hardware legacy cause events, one cycle each |
| hw_ecause | input | NVEC | Hardware extended cause events |
| vec_mode | input | 1 | Per-vector routing mode |
| msix_on | input | 1 | Vector messaging enabled |
| msi_on | input | 1 | Single message enabled |
| force_clr | input | 1 | Unconditional clear-on-read and auto-mask |
| route_map | input | 16 | Two routing bytes for legacy causes |
| automask | input | CW | Mask bits cleared after a read or write-1-to-clear |
| cause | output | CW | Legacy cause register |
| cause_en | output | CW | Legacy enable mask |
| xcause | output | NVEC | Extended cause register |
| xcause_en | output | NVEC | Extended enable mask |
| rd_data | output | CW | Value returned by the last cause read |
| vec_notify | output | NVEC | Per-vector notification pulses |
| msi_pulse | output | 1 | Single-message notification pulse |
| irq_level | output | 1 | Level interrupt line |

## Verification
The bench builds the unit with its default parameters: 32 legacy bits, 32 vectors, reset cause at bit 30, and the summary and asserted bits at bit 31. With these values the real mask constants and both routing bytes are exercised. Directed sequences cover mask-set of a pending cause, re-raise without notification, a clear and a raise colliding on one bit, and read-clear with auto-masking. A sweep then runs all sixteen combinations of the four mode inputs, each with pseudo-random operations, data, routing bytes and sparse hardware events. Every cycle is compared against an arithmetic model of the requirements.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
   typedef enum logic [3:0] {
      OP_IDLE  = 4'd0,
      OP_CSET  = 4'd1,
      OP_MSET  = 4'd2,
      OP_MCLR  = 4'd3,
      OP_CW1C  = 4'd4,
      OP_CRD   = 4'd5,
      OP_ECSET = 4'd6,
      OP_EMSET = 4'd7,
      OP_EMCLR = 4'd8,
      OP_ECCLR = 4'd9
   } irq_op_e;
endpackage

// File: rtl/nic_irq_lower.sv
module nic_irq_lower
   import nic_irq_pkg::*;
#(
   parameter int CW         = 32,
   parameter int NVEC       = 32,
   parameter int ASSERT_BIT = 31,
   parameter int OTHER_BIT  = 31
) (
   input  irq_op_e         op,
   input  logic [CW-1:0]   wdata,
   input  logic [NVEC-1:0] xmask,
   input  logic [CW-1:0]   automask,
   input  logic            vec_mode,
   input  logic            msix_on,
   input  logic            msi_on,
   input  logic            force_clr,
   input  logic [CW-1:0]   cause_i,
   input  logic [CW-1:0]   en_i,
   input  logic [NVEC-1:0] xcause_i,
   input  logic [NVEC-1:0] xen_i,
   output logic [CW-1:0]   cause_o,
   output logic [CW-1:0]   en_o,
   output logic [NVEC-1:0] xcause_o,
   output logic [NVEC-1:0] xen_o,
   output logic            rd_en,
   output logic            drop_irq
);
   logic clearing;
   logic quiet;

   assign clearing = op inside {OP_MCLR, OP_CW1C, OP_CRD, OP_EMCLR, OP_ECCLR};

   always_comb begin
      cause_o  = cause_i;
      en_o     = en_i;
      xcause_o = xcause_i;
      xen_o    = xen_i;
      rd_en    = 1'b0;
      case (op)
         OP_MCLR: en_o = en_i & ~wdata;
         OP_CW1C: begin
            // mask check sees the cause value before the write
            if (force_clr || ((|en_i) && cause_i[ASSERT_BIT]))
               en_o = en_i & ~automask;
            cause_o = cause_i & ~wdata;
         end
         OP_CRD: begin
            rd_en = 1'b1;
            if (force_clr || (en_i == '0) || !msix_on)
               cause_o = '0;
            // mask check sees the cause value after the read clear
            if (force_clr || ((|en_i) && cause_o[ASSERT_BIT]))
               en_o = en_i & ~automask;
         end
         OP_EMCLR: xen_o    = xen_i & ~(wdata[NVEC-1:0] & xmask);
         OP_ECCLR: xcause_o = xcause_i & ~(wdata[NVEC-1:0] & xmask);
         default: ;
      endcase
      quiet = clearing && ((cause_o & en_o) == '0) && !vec_mode;
      if (quiet)
         xcause_o[OTHER_BIT] = 1'b0;
      drop_irq = quiet && !msi_on && !msix_on;
   end
endmodule

// File: rtl/nic_irq_raise.sv
module nic_irq_raise
   import nic_irq_pkg::*;
#(
   parameter int            CW        = 32,
   parameter int            NVEC      = 32,
   parameter int            RST_BIT   = 30,
   parameter int            OTHER_BIT = 31,
   parameter logic [CW-1:0] EN_VALID  = 32'h77D4_FBFD
) (
   input  irq_op_e         op,
   input  logic [CW-1:0]   wdata,
   input  logic [NVEC-1:0] xmask,
   input  logic [CW-1:0]   hw_cause,
   input  logic [NVEC-1:0] hw_ecause,
   input  logic            vec_mode,
   input  logic            msix_on,
   input  logic            msi_on,
   input  logic [15:0]     route_map,
   input  logic [CW-1:0]   cause_i,
   input  logic [CW-1:0]   en_i,
   input  logic [NVEC-1:0] xcause_i,
   input  logic [NVEC-1:0] xen_i,
   output logic [CW-1:0]   cause_o,
   output logic [CW-1:0]   en_o,
   output logic [NVEC-1:0] xcause_o,
   output logic [NVEC-1:0] xen_o,
   output logic [NVEC-1:0] vec_fire,
   output logic            msi_fire,
   output logic            irq_fire
);
   localparam int            VW       = (NVEC > 1) ? $clog2(NVEC) : 1;
   localparam logic [CW-1:0] RST_MASK = CW'(1) << RST_BIT;

   logic [1:0][NVEC-1:0] hit;

   for (genvar s = 0; s < 2; s++) begin : g_slot
      wire [7:0] ab = route_map[8*s +: 8];
      assign hit[s] = (ab[7] && ({1'b0, ab[4:0]} < 6'(NVEC)))
                      ? (NVEC'(1) << ab[VW-1:0]) : '0;
   end

   logic [CW-1:0]   old_p, fresh, lset, mset;
   logic [NVEC-1:0] old_x, xset, xmset, route;

   always_comb begin
      lset  = hw_cause | ((op == OP_CSET) ? wdata : '0);
      mset  = (op == OP_MSET) ? (wdata & EN_VALID) : '0;
      xset  = hw_ecause | ((op == OP_ECSET) ? (wdata[NVEC-1:0] & xmask) : '0);
      xmset = (op == OP_EMSET) ? (wdata[NVEC-1:0] & xmask) : '0;
      old_p = cause_i & en_i;
      old_x = xcause_i & xen_i;
      cause_o  = cause_i | lset;
      en_o     = en_i | mset;
      xen_o    = xen_i | xmset;
      xcause_o = xcause_i | xset;
      fresh    = cause_o & en_o & ~old_p;
      route    = '0;
      vec_fire = '0;
      msi_fire = 1'b0;
      irq_fire = 1'b0;
      if (vec_mode) begin
         if (fresh[RST_BIT])
            route = route | hit[0];
         if (|(fresh & ~RST_MASK))
            route = route | hit[1];
         xcause_o = xcause_o | route;
         vec_fire = xcause_o & xen_o & ~old_x;
      end else if (|fresh) begin
         xcause_o[OTHER_BIT] = 1'b1;
         if (fresh[RST_BIT])
            xcause_o[RST_BIT] = 1'b1;
         if (msix_on)
            vec_fire[0] = 1'b1;
         else if (msi_on)
            msi_fire = 1'b1;
         else
            irq_fire = 1'b1;
      end
   end
endmodule

// File: rtl/nic_irq_notifier.sv
module nic_irq_notifier
   import nic_irq_pkg::*;
#(
   parameter int              CW          = 32,
   parameter int              NVEC        = 32,
   parameter int              RST_BIT     = 30,
   parameter int              ASSERT_BIT  = 31,
   parameter int              OTHER_BIT   = 31,
   parameter logic [CW-1:0]   EN_VALID    = 32'h77D4_FBFD,
   parameter logic [NVEC-1:0] XMASK_VEC   = 32'h01FF_FFFF,
   parameter logic [NVEC-1:0] XMASK_SINGLE = 32'hC000_017F
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      sw_op,
   input  logic [CW-1:0]   sw_wdata,
   input  logic [CW-1:0]   hw_cause,
   input  logic [NVEC-1:0] hw_ecause,
   input  logic            vec_mode,
   input  logic            msix_on,
   input  logic            msi_on,
   input  logic            force_clr,
   input  logic [15:0]     route_map,
   input  logic [CW-1:0]   automask,
   output logic [CW-1:0]   cause,
   output logic [CW-1:0]   cause_en,
   output logic [NVEC-1:0] xcause,
   output logic [NVEC-1:0] xcause_en,
   output logic [CW-1:0]   rd_data,
   output logic [NVEC-1:0] vec_notify,
   output logic            msi_pulse,
   output logic            irq_level
);
   if (NVEC < 2 || NVEC > 32 || NVEC > CW) begin : g_bad_nvec
      $error("NVEC must lie in 2..32 and not exceed CW");
   end
   if (RST_BIT >= CW || ASSERT_BIT >= CW || RST_BIT >= NVEC || OTHER_BIT >= NVEC) begin : g_bad_bit
      $error("cause bit positions out of range");
   end

   irq_op_e         op;
   logic [NVEC-1:0] xmask;
   logic [CW-1:0]   c_l, e_l, c_r, e_r;
   logic [NVEC-1:0] x_l, xe_l, x_r, xe_r, vfire;
   logic            rd_en, drop_irq, mfire, ifire;

   assign op    = irq_op_e'(sw_op);
   assign xmask = vec_mode ? XMASK_VEC : XMASK_SINGLE;

   nic_irq_lower #(.CW(CW), .NVEC(NVEC), .ASSERT_BIT(ASSERT_BIT), .OTHER_BIT(OTHER_BIT)) u_lower (
      .op(op), .wdata(sw_wdata), .xmask(xmask), .automask(automask),
      .vec_mode(vec_mode), .msix_on(msix_on), .msi_on(msi_on), .force_clr(force_clr),
      .cause_i(cause), .en_i(cause_en), .xcause_i(xcause), .xen_i(xcause_en),
      .cause_o(c_l), .en_o(e_l), .xcause_o(x_l), .xen_o(xe_l),
      .rd_en(rd_en), .drop_irq(drop_irq)
   );

   nic_irq_raise #(.CW(CW), .NVEC(NVEC), .RST_BIT(RST_BIT), .OTHER_BIT(OTHER_BIT),
                   .EN_VALID(EN_VALID)) u_raise (
      .op(op), .wdata(sw_wdata), .xmask(xmask), .hw_cause(hw_cause), .hw_ecause(hw_ecause),
      .vec_mode(vec_mode), .msix_on(msix_on), .msi_on(msi_on), .route_map(route_map),
      .cause_i(c_l), .en_i(e_l), .xcause_i(x_l), .xen_i(xe_l),
      .cause_o(c_r), .en_o(e_r), .xcause_o(x_r), .xen_o(xe_r),
      .vec_fire(vfire), .msi_fire(mfire), .irq_fire(ifire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause      <= '0;
         cause_en   <= '0;
         xcause     <= '0;
         xcause_en  <= '0;
         rd_data    <= '0;
         vec_notify <= '0;
         msi_pulse  <= 1'b0;
         irq_level  <= 1'b0;
      end else begin
         cause      <= c_r;
         cause_en   <= e_r;
         xcause     <= x_r;
         xcause_en  <= xe_r;
         vec_notify <= vfire;
         msi_pulse  <= mfire;
         if (rd_en)
            rd_data <= cause;
         if (ifire)
            irq_level <= 1'b1;
         else if (drop_irq)
            irq_level <= 1'b0;
      end
   end
endmodule

// File: rtl/nic_irq_notifier_chk.sv
module nic_irq_notifier_chk #(
   parameter int            CW       = 32,
   parameter int            NVEC     = 32,
   parameter logic [CW-1:0] EN_VALID = 32'h77D4_FBFD
) (
   input logic            clk,
   input logic            rst_n,
   input logic [3:0]      sw_op,
   input logic [CW-1:0]   hw_cause,
   input logic            vec_mode,
   input logic            msix_on,
   input logic            msi_on,
   input logic            force_clr,
   input logic [CW-1:0]   cause,
   input logic [CW-1:0]   cause_en,
   input logic [NVEC-1:0] xcause,
   input logic [NVEC-1:0] xcause_en,
   input logic [NVEC-1:0] vec_notify,
   input logic            msi_pulse,
   input logic            irq_level
);
   // R3: a pulsed vector is pending and enabled right after the pulse
   assert_vec_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(vec_mode) && (|vec_notify)) |-> ((vec_notify & ~(xcause & xcause_en)) == '0));

   // R1: without an extended clear, a pulsed vector was not pending before
   assert_only_fresh_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(vec_mode) && ($past(sw_op) != 4'd8) && ($past(sw_op) != 4'd9))
      |-> ((vec_notify & $past(xcause & xcause_en)) == '0));

   // R4: the single-message pulse needs msi on, vector messaging off
   assert_msi_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      msi_pulse |-> ($past(msi_on) && !$past(msix_on) && !$past(vec_mode)));

   // R5: the level line only rises with both message kinds off
   assert_level_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_level) |-> (!$past(msi_on) && !$past(msix_on) && !$past(vec_mode)));

   // R6: newly enabled legacy mask bits are within the writable set
   assert_mask_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_en & ~$past(cause_en) & ~EN_VALID) == '0));

   // R8: a forced read leaves only the same-cycle hardware events
   assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(sw_op) == 4'd5) && $past(force_clr)) |-> (cause == $past(hw_cause)));
endmodule

bind nic_irq_notifier nic_irq_notifier_chk #(.CW(CW), .NVEC(NVEC), .EN_VALID(EN_VALID)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_op(sw_op), .hw_cause(hw_cause), .vec_mode(vec_mode),
   .msix_on(msix_on), .msi_on(msi_on), .force_clr(force_clr), .cause(cause),
   .cause_en(cause_en), .xcause(xcause), .xcause_en(xcause_en), .vec_notify(vec_notify),
   .msi_pulse(msi_pulse), .irq_level(irq_level)
);

// File: tb/sim_nic_irq_notifier.sv
`timescale 1ns/1ps
module sim_nic_irq_notifier;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0]  sw_op = '0;
   logic [31:0] sw_wdata = '0, hw_cause = '0, hw_ecause = '0, automask = '0;
   logic vec_mode = 0, msix_on = 0, msi_on = 0, force_clr = 0;
   logic [15:0] route_map = '0;
   logic [31:0] cause, cause_en, xcause, xcause_en, rd_data, vec_notify;
   logic msi_pulse, irq_level;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;

   logic [31:0] m_c = '0, m_e = '0, m_x = '0, m_xe = '0, m_rd = '0, e_vec = '0;
   logic m_irq = 0, e_msi = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;

   nic_irq_notifier u0 (
      .clk(clk), .rst_n(rst_n), .sw_op(sw_op), .sw_wdata(sw_wdata), .hw_cause(hw_cause),
      .hw_ecause(hw_ecause), .vec_mode(vec_mode), .msix_on(msix_on), .msi_on(msi_on),
      .force_clr(force_clr), .route_map(route_map), .automask(automask),
      .cause(cause), .cause_en(cause_en), .xcause(xcause), .xcause_en(xcause_en),
      .rd_data(rd_data), .vec_notify(vec_notify), .msi_pulse(msi_pulse), .irq_level(irq_level)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   // arithmetic model of the requirements
   task automatic model(input logic [3:0] op, input logic [31:0] d, hw, hwx);
      logic [31:0] xm, c, e, x, xe, fresh, oldp, oldx, rt;
      xm = vec_mode ? 32'h01FF_FFFF : 32'hC000_017F;
      c = m_c; e = m_e; x = m_x; xe = m_xe; e_vec = '0; e_msi = 0;
      case (op)
         4'd3: e = e & ~d;
         4'd4: begin
            if (force_clr || (e != 0 && c[31])) e = e & ~automask;
            c = c & ~d;
         end
         4'd5: begin
            m_rd = c;
            if (force_clr || e == 0 || !msix_on) c = '0;
            if (force_clr || (e != 0 && c[31])) e = e & ~automask;
         end
         4'd8: xe = xe & ~(d & xm);
         4'd9: x = x & ~(d & xm);
         default: ;
      endcase
      if ((op inside {4'd3, 4'd4, 4'd5, 4'd8, 4'd9}) && (c & e) == 0 && !vec_mode) begin
         x[31] = 1'b0;
         if (!msi_on && !msix_on) m_irq = 1'b0;
      end
      oldp = c & e; oldx = x & xe;
      c  = c | hw | ((op == 4'd1) ? d : '0);
      e  = e | ((op == 4'd2) ? (d & 32'h77D4_FBFD) : '0);
      x  = x | hwx | ((op == 4'd6) ? (d & xm) : '0);
      xe = xe | ((op == 4'd7) ? (d & xm) : '0);
      fresh = c & e & ~oldp;
      if (vec_mode) begin
         rt = '0;
         if (fresh[30] && route_map[7]) rt[route_map[4:0]] = 1'b1;
         if ((fresh & ~32'h4000_0000) != 0 && route_map[15]) rt[route_map[12:8]] = 1'b1;
         x = x | rt;
         e_vec = x & xe & ~oldx;
      end else if (fresh != 0) begin
         x[31] = 1'b1;
         if (fresh[30]) x[30] = 1'b1;
         if (msix_on) e_vec = 32'h1;
         else if (msi_on) e_msi = 1'b1;
         else m_irq = 1'b1;
      end
      m_c = c; m_e = e; m_x = x; m_xe = xe;
   endtask

   task automatic step(input logic [3:0] op, input logic [31:0] d, hw, hwx);
      sw_op = op; sw_wdata = d; hw_cause = hw; hw_ecause = hwx;
      model(op, d, hw, hwx);
      @(negedge clk);
      chk("R8 cause", cause, m_c);
      chk("R6 cause_en", cause_en, m_e);
      chk("R2 xcause", xcause, m_x);
      chk("R7 xcause_en", xcause_en, m_xe);
      chk("R8 rd_data", rd_data, m_rd);
      chk("R3 vec_notify", vec_notify, e_vec);
      chk("R4 msi_pulse", {31'b0, msi_pulse}, {31'b0, e_msi});
      chk("R5 irq_level", {31'b0, irq_level}, {31'b0, m_irq});
      sw_op = '0; sw_wdata = '0; hw_cause = '0; hw_ecause = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 cause", cause, 0);
      chk("R12 xcause", xcause, 0);
      chk("R12 vec", vec_notify, 0);
      chk("R12 level", {31'b0, irq_level}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      msi_on = 1;
      step(0, 0, 32'h1, 0);                      // pending but masked
      chk("R1 masked no pulse", {31'b0, msi_pulse}, 0);
      step(2, 32'h1, 0, 0);                      // unmask pending cause
      chk("R7 mask-set notifies", {31'b0, msi_pulse}, 1);
      chk("R4 summary bit", xcause, 32'h8000_0000);
      step(0, 0, 32'h1, 0);                      // re-raise
      chk("R1 re-raise silent", {31'b0, msi_pulse}, 0);
      step(0, 0, 32'h2, 0);
      step(2, 32'h2, 0, 0);                      // bit1 not writable
      chk("R6 mask filter", cause_en, 32'h1);
      chk("R6 no pulse", {31'b0, msi_pulse}, 0);
      step(3, 32'h1, 0, 0);                      // mask clear empties pending
      chk("R5 summary cleared", xcause, 0);
      chk("R7 clear silent", {31'b0, msi_pulse}, 0);
      msi_on = 0;
      step(2, 32'h1, 0, 0);
      chk("R7 level raised", {31'b0, irq_level}, 1);
      step(4, 32'h1, 0, 0);
      chk("R5 level dropped", {31'b0, irq_level}, 0);
      step(4, 32'h4, 32'h4, 0);                  // clear and raise collide
      chk("R10 raise survives", cause & 32'h4, 32'h4);
      force_clr = 1; automask = 32'h1;
      step(5, 0, 0, 0);
      chk("R8 read value", rd_data, 32'h6);
      chk("R8 read cleared", cause, 0);
      chk("R9 automask", cause_en, 0);
      force_clr = 0; automask = 0;
      vec_mode = 1; route_map = 16'h8385;
      step(7, 32'h28, 0, 0);
      step(2, 32'h4000_0001, 0, 0);
      step(0, 0, 32'h4000_0000, 0);
      chk("R2 reset cause to vector 5", vec_notify, 32'h20);
      step(0, 0, 32'h1, 0);
      chk("R2 other cause to vector 3", vec_notify, 32'h08);
      chk("R11 pulse one cycle", {31'b0, msi_pulse}, 0);
      step(0, 0, 32'h1, 0);
      chk("R1 vector re-raise silent", vec_notify, 0);

      // sweep over every mode combination
      for (int m = 0; m < 16; m++) begin
         vec_mode = m[0]; msix_on = m[1]; msi_on = m[2]; force_clr = m[3];
         route_map = rnd()[15:0];
         automask = rnd() & rnd();
         for (int i = 0; i < 300; i++) begin
            logic [31:0] r, d, hw, hwx;
            r = rnd();
            d = rnd();
            if (r[7:6] == 2'b00) d = d & rnd();
            hw  = (r[8]) ? (rnd() & rnd() & rnd()) : '0;
            hwx = (r[9]) ? (rnd() & rnd() & rnd()) : '0;
            step(4'(r[3:0] % 10), d, hw, hwx);
         end
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule